// File: doc/BRIEF.md
# SATA Out-of-Band Transmit Sequencer

This block drives the transmit side of a serial link during out-of-band signalling. A one-cycle request selects one of three signalling patterns: reset/init, wake, or SAS. The block then sends a fixed number of bursts of the D10.2 symbol. Each burst is followed by an electrical-idle gap. The three patterns share the same burst length and differ only in the length of the gap.

Burst and gap lengths are counted in clock cycles. The link generation scales them, because each faster generation runs the symbol clock at twice the rate of the one below. Completion is timed by the block's own counters. The PHY's finish indication is never used, because it can still belong to the previous sequence.

When no sequence is running, the block is transparent. It passes the link layer's symbols straight through and follows the link layer's electrical-idle request.

Top module: `oob_tx_sequencer`

## Requirements
- R1: After reset, `busy` and `done` are low and the block is in pass-through mode.
- R2: While `busy` is low, `tx_elec_idle` equals `link_idle` and `tx_data` equals `data_in` in the same cycle.
- R3: A `req` pulse with `req_sel` 0 (reset/init), 1 (wake) or 2 (SAS) while `busy` is low starts a sequence. From the next cycle `busy` is high and the first burst is on the outputs. A `req` with `req_sel` 3 is ignored and `busy` stays low.
- R4: A sequence consists of `BURSTS` (default 6) bursts, each followed by a gap. During a burst `tx_elec_idle` is low and `tx_data` is 10'h155 (D10.2). During a gap `tx_elec_idle` is high and `tx_data` is zero.
- R5: A burst lasts `BURST_BASE << g` cycles. Here g is `gen` sampled at the request: 0 for Gen1, 1 for Gen2, 2 for Gen3, and code 3 is treated as 2. The default `BURST_BASE` is 4.
- R6: A gap lasts `BURST_BASE * m << g` cycles. The multiplier m is 3 for reset/init, 1 for wake and 9 for SAS.
- R7: `done` is a one-cycle pulse in the cycle right after the last gap. `busy` falls in that same cycle.
- R8: While `busy` is high, further `req` pulses are ignored, and so are changes on `req_sel` and `gen`.
- R9: `phy_done` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen | input | 2 | Link generation code (0 = Gen1, 1 = Gen2, 2/3 = Gen3) |
| req | input | 1 | One-cycle sequence request |
| req_sel | input | 2 | Pattern select: 0 reset/init, 1 wake, 2 SAS, 3 reserved |
| link_idle | input | 1 | Electrical-idle request from the link layer, used when not busy |
| data_in | input | 10 | Symbol from the link layer, used when not busy |
| phy_done | input | 1 | PHY finish strobe, ignored |
| tx_elec_idle | output | 1 | Transmit electrical-idle control |
| tx_data | output | 10 | Transmit symbol |
| busy | output | 1 | High while a sequence is being sent |
| done | output | 1 | One-cycle completion strobe |

## Verification
A wrong burst or gap counter shows at the ports as a burst/idle edge that moves by one or more cycles. This is visible within the first burst period after the request.

A wrong burst index or a latched parameter taken from the live inputs changes where `done` lands. That shows only at the end of the sequence, up to roughly a thousand cycles later.

A completion path that leaked `phy_done` would show `done` while `busy` is still high. The stimulus injects `phy_done` on random cycles so that such a leak appears within a few cycles.

// File: rtl/oob_pkg.sv
package oob_pkg;

   typedef enum logic [1:0] {
      SEQ_RESET = 2'd0,
      SEQ_WAKE  = 2'd1,
      SEQ_SAS   = 2'd2,
      SEQ_NONE  = 2'd3
   } oob_seq_e;

   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_BURST = 2'd1,
      ST_GAP   = 2'd2
   } oob_state_e;

   localparam logic [9:0] SYM_D10_2 = 10'h155;

endpackage

// File: rtl/oob_timing.sv
module oob_timing #(
   parameter int BURST_BASE   = 4,
   parameter int GAP_RST_MUL  = 3,
   parameter int GAP_WAKE_MUL = 1,
   parameter int GAP_SAS_MUL  = 9,
   parameter int GEN_COUNT    = 3,
   parameter int CW           = 8
) (
   input  logic [1:0]    gen_q,
   input  oob_pkg::oob_seq_e sel_q,
   output logic [CW-1:0] burst_len,
   output logic [CW-1:0] gap_len
);
   import oob_pkg::*;

   localparam int MAX_SHIFT = GEN_COUNT - 1;
   localparam int MAX_LEN   = (BURST_BASE * GAP_SAS_MUL) << MAX_SHIFT;

   int mul_tab [3];

   generate
      if (BURST_BASE < 1) begin : g_bad_base
         $error("BURST_BASE must be at least 1");
      end
      if (GEN_COUNT < 1 || GEN_COUNT > 4) begin : g_bad_gen
         $error("GEN_COUNT must be 1..4");
      end
      if ((1 << CW) <= MAX_LEN) begin : g_bad_cw
         $error("CW too narrow for longest gap");
      end
      for (genvar s = 0; s < 3; s++) begin : g_mul
         localparam int MUL = (s == 0) ? GAP_RST_MUL :
                              (s == 1) ? GAP_WAKE_MUL : GAP_SAS_MUL;
         if (MUL < 1) begin : g_bad_mul
            $error("gap multipliers must be at least 1");
         end
         assign mul_tab[s] = MUL;
      end
   endgenerate

   int shift;
   int mul;

   always_comb begin
      shift = (int'(gen_q) > MAX_SHIFT) ? MAX_SHIFT : int'(gen_q);
      case (sel_q)
         SEQ_WAKE: mul = mul_tab[1];
         SEQ_SAS:  mul = mul_tab[2];
         default:  mul = mul_tab[0];
      endcase
      burst_len = CW'(BURST_BASE << shift);
      gap_len   = CW'((BURST_BASE * mul) << shift);
   end

endmodule

// File: rtl/oob_ctrl.sv
module oob_ctrl #(
   parameter int BURSTS = 6,
   parameter int CW     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] burst_len,
   input  logic [CW-1:0] gap_len,
   output logic          in_burst,
   output logic          busy,
   output logic          done
);
   import oob_pkg::*;

   localparam int IW = (BURSTS > 1) ? $clog2(BURSTS) : 1;

   generate
      if (BURSTS < 1) begin : g_bad_bursts
         $error("BURSTS must be at least 1");
      end
   endgenerate

   oob_state_e    st;
   logic [CW-1:0] cnt;
   logic [IW-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_OFF;
         cnt  <= '0;
         idx  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_OFF: begin
               if (start) begin
                  st  <= ST_BURST;
                  cnt <= '0;
                  idx <= '0;
               end
            end
            ST_BURST: begin
               if (cnt == burst_len - CW'(1)) begin
                  st  <= ST_GAP;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            ST_GAP: begin
               if (cnt == gap_len - CW'(1)) begin
                  cnt <= '0;
                  if (idx == IW'(BURSTS - 1)) begin
                     st   <= ST_OFF;
                     done <= 1'b1;
                  end else begin
                     idx <= idx + IW'(1);
                     st  <= ST_BURST;
                  end
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            default: st <= ST_OFF;
         endcase
      end
   end

   assign busy     = (st != ST_OFF);
   assign in_burst = (st == ST_BURST);

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);   // R7
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));   // R7

endmodule

// File: rtl/oob_tx_sequencer.sv
module oob_tx_sequencer #(
   parameter int SYM_W        = 10,
   parameter int BURSTS       = 6,
   parameter int BURST_BASE   = 4,
   parameter int GAP_RST_MUL  = 3,
   parameter int GAP_WAKE_MUL = 1,
   parameter int GAP_SAS_MUL  = 9,
   parameter int GEN_COUNT    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       gen,
   input  logic             req,
   input  logic [1:0]       req_sel,
   input  logic             link_idle,
   input  logic [SYM_W-1:0] data_in,
   input  logic             phy_done,
   output logic             tx_elec_idle,
   output logic [SYM_W-1:0] tx_data,
   output logic             busy,
   output logic             done
);
   import oob_pkg::*;

   localparam int MAX_LEN = (BURST_BASE * GAP_SAS_MUL) << (GEN_COUNT - 1);
   localparam int CW      = $clog2(MAX_LEN + 1) + 1;

   generate
      if (SYM_W != 10) begin : g_bad_symw
         $error("SYM_W must be 10 for 8b/10b symbols");
      end
   endgenerate

   logic       start;
   logic       in_burst;
   logic [1:0] gen_q;
   oob_seq_e   sel_q;
   logic [CW-1:0] burst_len;
   logic [CW-1:0] gap_len;

   assign start = req && !busy && (oob_seq_e'(req_sel) != SEQ_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_q <= '0;
         sel_q <= SEQ_RESET;
      end else if (start) begin
         gen_q <= gen;
         sel_q <= oob_seq_e'(req_sel);
      end
   end

   oob_timing #(
      .BURST_BASE  (BURST_BASE),
      .GAP_RST_MUL (GAP_RST_MUL),
      .GAP_WAKE_MUL(GAP_WAKE_MUL),
      .GAP_SAS_MUL (GAP_SAS_MUL),
      .GEN_COUNT   (GEN_COUNT),
      .CW          (CW)
   ) u_timing (
      .gen_q    (gen_q),
      .sel_q    (sel_q),
      .burst_len(burst_len),
      .gap_len  (gap_len)
   );

   oob_ctrl #(
      .BURSTS(BURSTS),
      .CW    (CW)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .burst_len(burst_len),
      .gap_len  (gap_len),
      .in_burst (in_burst),
      .busy     (busy),
      .done     (done)
   );

   always_comb begin
      if (!busy) begin
         tx_elec_idle = link_idle;
         tx_data      = data_in;
      end else if (in_burst) begin
         tx_elec_idle = 1'b0;
         tx_data      = SYM_D10_2;
      end else begin
         tx_elec_idle = 1'b1;
         tx_data      = '0;
      end
   end

   AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req) |=> (busy || done));   // R8
   AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(gen_q) && $stable(sel_q)));   // R8
   AST_PHY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_done && !busy) |=> !done);   // R9
   AST_BURST_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tx_elec_idle) |-> (tx_data == SYM_D10_2));   // R4

endmodule

// File: tb/oob_tx_sequencer_bench.sv
module oob_tx_sequencer_bench;

   localparam int BURSTS     = 6;
   localparam int BURST_BASE = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] gen = '0;
   logic       req = 1'b0;
   logic [1:0] req_sel = '0;
   logic       link_idle = 1'b0;
   logic [9:0] data_in = '0;
   logic       phy_done = 1'b0;
   logic       tx_elec_idle;
   logic [9:0] tx_data;
   logic       busy;
   logic       done;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   oob_tx_sequencer u_oob_tx_sequencer (
      .clk(clk), .rst_n(rst_n), .gen(gen), .req(req), .req_sel(req_sel),
      .link_idle(link_idle), .data_in(data_in), .phy_done(phy_done),
      .tx_elec_idle(tx_elec_idle), .tx_data(tx_data), .busy(busy), .done(done)
   );

   function automatic int f_shift(input logic [1:0] g);
      return (g == 2'd3) ? 2 : int'(g);
   endfunction

   function automatic int f_burst(input logic [1:0] g);
      return BURST_BASE << f_shift(g);
   endfunction

   function automatic int f_gap(input logic [1:0] s, input logic [1:0] g);
      int m;
      m = (s == 2'd1) ? 1 : (s == 2'd2) ? 9 : 3;
      return (BURST_BASE * m) << f_shift(g);
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
      end
   endtask

   // Passthrough check, R2
   task automatic pass_check(input logic li, input logic [9:0] d);
      link_idle = li;
      data_in   = d;
      #1;
      chk(tx_elec_idle == li, "R2 idle follow", tx_elec_idle, li);
      chk(tx_data == d, "R2 data follow", tx_data, d);
   endtask

   // Runs one sequence; called at a negedge with busy low.
   task automatic run_seq(input logic [1:0] s, input logic [1:0] g, input bit noise);
      int b, p, tot;
      b   = f_burst(g);
      p   = b + f_gap(s, g);
      tot = BURSTS * p;
      req = 1'b1; req_sel = s; gen = g;
      @(negedge clk);
      req = 1'b0;
      for (int k = 0; k < tot; k++) begin
         #1;
         chk(busy == 1'b1, "R3 busy during sequence", busy, 1);
         chk(done == 1'b0, "R9 no early done", done, 0);
         if ((k % p) < b) begin
            chk(tx_elec_idle == 1'b0, "R5 burst timing", tx_elec_idle, 0);
            chk(tx_data == 10'h155, "R4 burst symbol", tx_data, 10'h155);
         end else begin
            chk(tx_elec_idle == 1'b1, "R6 gap timing", tx_elec_idle, 1);
            chk(tx_data == 10'h000, "R4 gap data", tx_data, 0);
         end
         if (noise) begin
            req      = ($urandom_range(0, 9) == 0);
            req_sel  = 2'($urandom_range(0, 3));
            gen      = 2'($urandom_range(0, 3));
            phy_done = $urandom_range(0, 1) == 1;
            data_in  = 10'($urandom);
            link_idle = $urandom_range(0, 1) == 1;
         end
         @(negedge clk);
      end
      req = 1'b0; phy_done = 1'b0;
      #1;
      chk(done == 1'b1, "R7 done after last gap", done, 1);
      chk(busy == 1'b0, "R7 busy falls with done", busy, 0);
      @(negedge clk);
      #1;
      chk(done == 1'b0, "R7 done single cycle", done, 0);
      chk(busy == 1'b0, "R8 no restart from ignored req", busy, 0);
   endtask

   initial begin
      fork
         begin
            void'($urandom(32'd1234));
            #3;
            chk(busy == 1'b0 && done == 1'b0, "R1 reset state", {busy, done}, 0);
            pass_check(1'b1, 10'h2AA);
            @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            chk(busy == 1'b0, "R1 idle after reset", busy, 0);
            for (int i = 0; i < 8; i++) pass_check($urandom_range(0, 1) == 1, 10'($urandom));
            // R3 reserved select ignored
            req = 1'b1; req_sel = 2'd3;
            @(negedge clk);
            req = 1'b0;
            #1;
            chk(busy == 1'b0, "R3 reserved select ignored", busy, 0);
            // R9 phy_done while idle
            phy_done = 1'b1;
            @(negedge clk);
            phy_done = 1'b0;
            #1;
            chk(done == 1'b0, "R9 phy_done idle ignored", done, 0);
            @(negedge clk);
            // directed corners
            run_seq(2'd0, 2'd0, 1'b0);
            run_seq(2'd1, 2'd1, 1'b1);
            run_seq(2'd2, 2'd2, 1'b1);
            run_seq(2'd0, 2'd3, 1'b1);
            // random mix
            for (int i = 0; i < 6; i++) begin
               run_seq(2'($urandom_range(0, 2)), 2'($urandom_range(0, 3)), 1'b1);
               pass_check($urandom_range(0, 1) == 1, 10'($urandom));
               @(negedge clk);
            end
         end
         begin
            repeat (150000) @(posedge clk);
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule